// File: doc/BRIEF.md
# Hardwired Instruction Sequencing Controller

This block is the control unit of a small 16-bit load/store processor. It is a numbered-state machine with fixed wiring. It steps through instruction fetch, a decode-and-dispatch state, and the complete execution path of a PC-relative store. In every cycle it raises the bus gates, register load strobes, multiplexer selects and memory strobes that a separate datapath needs. The datapath itself (registers, adders, ALU and memory) lives outside the block. The controller sees that datapath only through a few instruction-register bits, the three condition flags, a memory-ready handshake and an interrupt request.

Every control output is a pure function of the current state. Memory states wait as long as memory-ready stays low, so the number of cycles an instruction takes is not fixed. During decode the block captures a branch-enable bit. This bit combines the instruction's condition-mask bits with the live flags. Only the store opcode has an execution path. Every other opcode raises an unimplemented flag for one cycle and returns to fetch. A pending interrupt at the start of fetch is answered with a one-cycle acknowledge.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While rst_n is low, every control output and ben are 0. Once rst_n is high, the block is in the fetch state and drives the fetch control word.
- R2: In the fetch state the asserted controls are exactly gate_pc, ld_mar and ld_pc, with pc_mux_sel = 2'b00 (PC plus one). Every other control is 0.
- R3: If irq is high in the fetch state, the next cycle asserts int_ack alone. The cycle after that is fetch again.
- R4: If irq is low in the fetch state, the next cycle is the memory read state: mem_en=1, ld_mdr=1, mem_we=0, nothing else. The block stays in that state while mem_rdy is low.
- R5: When mem_rdy is high in the read state, the next cycle asserts gate_mdr and ld_ir only. The cycle after that is decode, which asserts ld_ben only.
- R6: At the end of decode, ben takes the value (ir_nzp[2]&flag_n)|(ir_nzp[1]&flag_z)|(ir_nzp[0]&flag_p). ir_nzp holds instruction bits 11:9. ben then holds until the next decode.
- R7: When ir_opcode (instruction bits 15:12) equals 4'b0011 in decode, the next cycle is the store-address state: ld_mar, gate_marmux, marmux_sel=1 (adder), addr1_sel=0 (PC), addr2_sel=2'b10 (sign-extended 9-bit offset).
- R8: The store-address state is always followed by the store-operand state: gate_alu, ld_mdr, sr1_sel=2'b00 (register number from bits 11:9), alu_op=2'b11 (pass-through).
- R9: The store-operand state is followed by the write state: mem_en=1, mem_we=1. The block stays there while mem_rdy is low, then returns to fetch.
- R10: Any other opcode in decode leads to exactly one cycle with unimpl_op alone, followed by fetch.
- R11: At most one of the four bus gates is high in any cycle, and mem_we is never high without mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ir_opcode | input | 4 | Instruction bits 15:12 |
| ir_nzp | input | 3 | Instruction bits 11:9 (condition mask / source register) |
| flag_n | input | 1 | Negative condition flag |
| flag_z | input | 1 | Zero condition flag |
| flag_p | input | 1 | Positive condition flag |
| mem_rdy | input | 1 | Memory access complete |
| irq | input | 1 | Interrupt pending |
| gate_pc | output | 1 | Drive PC onto the bus |
| gate_marmux | output | 1 | Drive address mux onto the bus |
| gate_mdr | output | 1 | Drive MDR onto the bus |
| gate_alu | output | 1 | Drive ALU result onto the bus |
| ld_mar | output | 1 | Load MAR |
| ld_mdr | output | 1 | Load MDR |
| ld_ir | output | 1 | Load IR |
| ld_pc | output | 1 | Load PC |
| ld_ben | output | 1 | Capture branch enable |
| pc_mux_sel | output | 2 | PC source select, 00 = PC plus one |
| marmux_sel | output | 1 | Address mux: 1 = address adder |
| addr1_sel | output | 1 | Adder base: 0 = PC |
| addr2_sel | output | 2 | Adder offset: 10 = 9-bit offset |
| sr1_sel | output | 2 | Source register field: 00 = bits 11:9 |
| alu_op | output | 2 | ALU function: 11 = pass |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| int_ack | output | 1 | Interrupt acknowledge pulse |
| unimpl_op | output | 1 | Unimplemented opcode pulse |
| ben | output | 1 | Latched branch-enable bit |

## Verification
The assertions assume that mem_rdy is only sampled as a completion when the controller is in a memory state. They also assume that ir_opcode and ir_nzp are stable through the decode cycle. The bench meets both assumptions because it changes inputs only on the falling edge and raises mem_rdy only inside a read or write wait. The sweep covers every opcode, every value of the condition-mask bits and every flag combination. It also varies the memory wait lengths, inserts interrupt requests at fetch, and applies one reset in the middle of a store.

// File: rtl/hw_seq_ctrl_pkg.sv
package hw_seq_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH    = 4'd0,
    ST_IRQ_ACK  = 4'd1,
    ST_MEM_RD   = 4'd2,
    ST_IR_LD    = 4'd3,
    ST_DECODE   = 4'd4,
    ST_STA_ADDR = 4'd5,
    ST_STA_OPND = 4'd6,
    ST_STA_WR   = 4'd7,
    ST_UNIMPL   = 4'd8
  } ctl_state_e;

  localparam logic [1:0] PCSEL_INC  = 2'b00;
  localparam logic [1:0] ADDR2_OFF9 = 2'b10;
  localparam logic [1:0] SR1_BITS9  = 2'b00;
  localparam logic [1:0] ALU_PASS   = 2'b11;

  typedef struct packed {
    logic       gate_pc;
    logic       gate_marmux;
    logic       gate_mdr;
    logic       gate_alu;
    logic       ld_mar;
    logic       ld_mdr;
    logic       ld_ir;
    logic       ld_pc;
    logic       ld_ben;
    logic [1:0] pc_mux_sel;
    logic       marmux_sel;
    logic       addr1_sel;
    logic [1:0] addr2_sel;
    logic [1:0] sr1_sel;
    logic [1:0] alu_op;
    logic       mem_en;
    logic       mem_we;
    logic       int_ack;
    logic       unimpl_op;
  } ctl_word_t;

endpackage

// File: rtl/hw_seq_next_state.sv
module hw_seq_next_state
  import hw_seq_ctrl_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] STORE_OPC = 4'b0011
) (
  input  ctl_state_e        cur_state,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              irq,
  input  logic              mem_rdy,
  output ctl_state_e        nxt_state
);

  always_comb begin
    nxt_state = cur_state;
    unique case (cur_state)
      ST_FETCH:    nxt_state = irq ? ST_IRQ_ACK : ST_MEM_RD;
      ST_IRQ_ACK:  nxt_state = ST_FETCH;
      ST_MEM_RD:   nxt_state = mem_rdy ? ST_IR_LD : ST_MEM_RD;
      ST_IR_LD:    nxt_state = ST_DECODE;
      ST_DECODE:   nxt_state = (opcode == STORE_OPC) ? ST_STA_ADDR : ST_UNIMPL;
      ST_STA_ADDR: nxt_state = ST_STA_OPND;
      ST_STA_OPND: nxt_state = ST_STA_WR;
      ST_STA_WR:   nxt_state = mem_rdy ? ST_FETCH : ST_STA_WR;
      ST_UNIMPL:   nxt_state = ST_FETCH;
      default:     nxt_state = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/hw_seq_out_decode.sv
module hw_seq_out_decode
  import hw_seq_ctrl_pkg::*;
(
  input  ctl_state_e cur_state,
  output ctl_word_t  word
);

  always_comb begin
    word = '0;
    unique case (cur_state)
      ST_FETCH: begin
        word.gate_pc    = 1'b1;
        word.ld_mar     = 1'b1;
        word.ld_pc      = 1'b1;
        word.pc_mux_sel = PCSEL_INC;
      end
      ST_IRQ_ACK: word.int_ack = 1'b1;
      ST_MEM_RD: begin
        word.mem_en = 1'b1;
        word.ld_mdr = 1'b1;
      end
      ST_IR_LD: begin
        word.gate_mdr = 1'b1;
        word.ld_ir    = 1'b1;
      end
      ST_DECODE: word.ld_ben = 1'b1;
      ST_STA_ADDR: begin
        word.ld_mar      = 1'b1;
        word.gate_marmux = 1'b1;
        word.marmux_sel  = 1'b1;
        word.addr1_sel   = 1'b0;
        word.addr2_sel   = ADDR2_OFF9;
      end
      ST_STA_OPND: begin
        word.gate_alu = 1'b1;
        word.ld_mdr   = 1'b1;
        word.sr1_sel  = SR1_BITS9;
        word.alu_op   = ALU_PASS;
      end
      ST_STA_WR: begin
        word.mem_en = 1'b1;
        word.mem_we = 1'b1;
      end
      ST_UNIMPL: word.unimpl_op = 1'b1;
      default:   word = '0;
    endcase
  end

endmodule

// File: rtl/hw_seq_ben_latch.sv
module hw_seq_ben_latch #(
  parameter int CC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [CC_W-1:0] mask,
  input  logic [CC_W-1:0] flags,
  output logic            ben
);

  logic ben_d;

  always_comb ben_d = |(mask & flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ben <= 1'b0;
    else if (load_en) ben <= ben_d;
  end

endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
  import hw_seq_ctrl_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] STORE_OPC = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] ir_opcode,
  input  logic [2:0]       ir_nzp,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_p,
  input  logic             mem_rdy,
  input  logic             irq,
  output logic             gate_pc,
  output logic             gate_marmux,
  output logic             gate_mdr,
  output logic             gate_alu,
  output logic             ld_mar,
  output logic             ld_mdr,
  output logic             ld_ir,
  output logic             ld_pc,
  output logic             ld_ben,
  output logic [1:0]       pc_mux_sel,
  output logic             marmux_sel,
  output logic             addr1_sel,
  output logic [1:0]       addr2_sel,
  output logic [1:0]       sr1_sel,
  output logic [1:0]       alu_op,
  output logic             mem_en,
  output logic             mem_we,
  output logic             int_ack,
  output logic             unimpl_op,
  output logic             ben
);

  ctl_state_e state_q, state_d;
  ctl_word_t  word_raw, word;

  hw_seq_next_state #(.OPC_W(OPC_W), .STORE_OPC(STORE_OPC)) u_next (
    .cur_state (state_q),
    .opcode    (ir_opcode),
    .irq       (irq),
    .mem_rdy   (mem_rdy),
    .nxt_state (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  hw_seq_out_decode u_dec (
    .cur_state (state_q),
    .word      (word_raw)
  );

  // Controls are held quiet for as long as reset is applied (R1)
  always_comb word = rst_n ? word_raw : '0;

  hw_seq_ben_latch #(.CC_W(3)) u_ben (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (word.ld_ben),
    .mask    (ir_nzp),
    .flags   ({flag_n, flag_z, flag_p}),
    .ben     (ben)
  );

  assign gate_pc     = word.gate_pc;
  assign gate_marmux = word.gate_marmux;
  assign gate_mdr    = word.gate_mdr;
  assign gate_alu    = word.gate_alu;
  assign ld_mar      = word.ld_mar;
  assign ld_mdr      = word.ld_mdr;
  assign ld_ir       = word.ld_ir;
  assign ld_pc       = word.ld_pc;
  assign ld_ben      = word.ld_ben;
  assign pc_mux_sel  = word.pc_mux_sel;
  assign marmux_sel  = word.marmux_sel;
  assign addr1_sel   = word.addr1_sel;
  assign addr2_sel   = word.addr2_sel;
  assign sr1_sel     = word.sr1_sel;
  assign alu_op      = word.alu_op;
  assign mem_en      = word.mem_en;
  assign mem_we      = word.mem_we;
  assign int_ack     = word.int_ack;
  assign unimpl_op   = word.unimpl_op;

  AST_SINGLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_pc, gate_marmux, gate_mdr, gate_alu})); // R11
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R11
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_pc && irq) |=> (int_ack && !ld_mar)); // R3
  AST_ACK_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (gate_pc && !int_ack)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && !mem_rdy) |=> (mem_en && !mem_we && ld_mdr)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_rdy) |=> mem_we); // R9
  AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_rdy) |=> gate_pc); // R9
  AST_UNIMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_op |=> (!unimpl_op && gate_pc)); // R10
  AST_BEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ben |=> $stable(ben)); // R6
  AST_OPND_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    gate_marmux |=> (gate_alu && ld_mdr)); // R8

endmodule

// File: tb/hw_seq_ctrl_tb.sv
module hw_seq_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int CW    = 23;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] ir_opcode;
  logic [2:0] ir_nzp;
  logic flag_n, flag_z, flag_p, mem_rdy, irq;
  logic gate_pc, gate_marmux, gate_mdr, gate_alu, ld_mar, ld_mdr, ld_ir, ld_pc, ld_ben;
  logic [1:0] pc_mux_sel, addr2_sel, sr1_sel, alu_op;
  logic marmux_sel, addr1_sel, mem_en, mem_we, int_ack, unimpl_op, ben;

  int checks = 0;
  int errors = 0;
  logic exp_ben;

  always #(CLK_P/2) clk = ~clk;

  hw_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_nzp(ir_nzp),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .mem_rdy(mem_rdy), .irq(irq),
    .gate_pc(gate_pc), .gate_marmux(gate_marmux), .gate_mdr(gate_mdr), .gate_alu(gate_alu),
    .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_ben(ld_ben),
    .pc_mux_sel(pc_mux_sel), .marmux_sel(marmux_sel), .addr1_sel(addr1_sel),
    .addr2_sel(addr2_sel), .sr1_sel(sr1_sel), .alu_op(alu_op), .mem_en(mem_en),
    .mem_we(mem_we), .int_ack(int_ack), .unimpl_op(unimpl_op), .ben(ben)
  );

  // Bit order: gates(4) loads(5) pc_mux(2) marmux addr1 addr2(2) sr1(2) alu(2) en we ack unimpl
  function automatic logic [CW-1:0] observed();
    return {gate_pc, gate_marmux, gate_mdr, gate_alu, ld_mar, ld_mdr, ld_ir, ld_pc, ld_ben,
            pc_mux_sel, marmux_sel, addr1_sel, addr2_sel, sr1_sel, alu_op,
            mem_en, mem_we, int_ack, unimpl_op};
  endfunction

  function automatic logic [CW-1:0] mk(
    logic gpc, logic gmm, logic gmdr, logic galu, logic lmar, logic lmdr, logic lir,
    logic lpc, logic lben, logic [1:0] pcs, logic mms, logic a1, logic [1:0] a2,
    logic [1:0] sr, logic [1:0] alu, logic en, logic we, logic ack, logic un);
    return {gpc, gmm, gmdr, galu, lmar, lmdr, lir, lpc, lben, pcs, mms, a1, a2, sr, alu,
            en, we, ack, un};
  endfunction

  logic [CW-1:0] W_FETCH, W_ACK, W_RD, W_IRLD, W_DEC, W_SADDR, W_SOPND, W_SWR, W_UNIMPL;
  initial begin
    W_FETCH  = mk(1,0,0,0, 1,0,0,1,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 0,0,0,0);
    W_ACK    = mk(0,0,0,0, 0,0,0,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 0,0,1,0);
    W_RD     = mk(0,0,0,0, 0,1,0,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 1,0,0,0);
    W_IRLD   = mk(0,0,1,0, 0,0,1,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 0,0,0,0);
    W_DEC    = mk(0,0,0,0, 0,0,0,0,1, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 0,0,0,0);
    W_SADDR  = mk(0,1,0,0, 1,0,0,0,0, 2'b00, 1,0,2'b10, 2'b00, 2'b00, 0,0,0,0);
    W_SOPND  = mk(0,0,0,1, 0,1,0,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b11, 0,0,0,0);
    W_SWR    = mk(0,0,0,0, 0,0,0,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 1,1,0,0);
    W_UNIMPL = mk(0,0,0,0, 0,0,0,0,0, 2'b00, 0,0,2'b00, 2'b00, 2'b00, 0,0,0,1);
  end

  task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_ben(input logic exp);
    checks++;
    if (ben !== exp) begin
      errors++;
      $display("FAIL R6 ben actual=%b expected=%b t=%0t", ben, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // One instruction, starting in fetch at a sampling point
  task automatic run_instr(input logic [3:0] opc, input logic [2:0] cc, input logic [2:0] nzp,
                           input int rd_wait, input int wr_wait, input logic take_irq);
    chk(observed(), W_FETCH, "R2 fetch");
    if (take_irq) begin
      irq = 1'b1;
      tick();
      irq = 1'b0;
      chk(observed(), W_ACK, "R3 ack");
      tick();
      chk(observed(), W_FETCH, "R3 back to fetch");
    end
    tick();
    for (int k = 0; k < rd_wait; k++) begin
      chk(observed(), W_RD, "R4 read wait");
      tick();
    end
    chk(observed(), W_RD, "R4 read");
    mem_rdy = 1'b1;
    tick();
    mem_rdy = 1'b0;
    chk(observed(), W_IRLD, "R5 ir load");
    tick();
    chk(observed(), W_DEC, "R5 decode");
    ir_opcode = opc;
    ir_nzp = cc;
    {flag_n, flag_z, flag_p} = nzp;
    exp_ben = (cc[2] & nzp[2]) | (cc[1] & nzp[1]) | (cc[0] & nzp[0]);
    tick();
    {flag_n, flag_z, flag_p} = ~nzp;
    chk_ben(exp_ben);
    if (opc == 4'b0011) begin
      chk(observed(), W_SADDR, "R7 store address");
      tick();
      chk(observed(), W_SOPND, "R8 store operand");
      tick();
      for (int k = 0; k < wr_wait; k++) begin
        chk(observed(), W_SWR, "R9 write wait");
        tick();
      end
      chk(observed(), W_SWR, "R9 write");
      mem_rdy = 1'b1;
      tick();
      mem_rdy = 1'b0;
    end else begin
      chk(observed(), W_UNIMPL, "R10 unimplemented");
      tick();
    end
    chk_ben(exp_ben);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ir_opcode = 4'b0011; ir_nzp = 3'b111;
    {flag_n, flag_z, flag_p} = 3'b111;
    mem_rdy = 1'b1; irq = 1'b1;
    repeat (3) tick();
    chk(observed(), '0, "R1 reset quiet");
    chk_ben(1'b0);
    mem_rdy = 1'b0; irq = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(observed(), W_FETCH, "R1 fetch after reset");

    for (int i = 0; i < 1024; i++) begin
      run_instr(4'(i >> 6), 3'(i >> 3), 3'(i), i % 3, (i / 3) % 4, (i % 5) == 0);
    end

    // Reset in the middle of a store write wait
    chk(observed(), W_FETCH, "R2 fetch");
    tick();
    mem_rdy = 1'b1; tick(); mem_rdy = 1'b0;
    tick();
    ir_opcode = 4'b0011; ir_nzp = 3'b010; {flag_n, flag_z, flag_p} = 3'b010;
    tick(); tick(); tick();
    chk(observed(), W_SWR, "R9 write before reset");
    rst_n = 1'b0;
    #1;
    chk(observed(), '0, "R1 reset mid-store");
    chk_ben(1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(observed(), W_FETCH, "R1 fetch after mid reset");
    tick();
    chk(observed(), W_RD, "R4 read after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule